// File: doc/BRIEF.md
# Configuration Byte Read Controller

This block lets firmware read the device's configuration fuse byte and lock bits through the ordinary program-memory load path. It holds a small self-programming control register with two flags, an enable flag and a read-configuration flag. Firmware sets both flags with one register write. A load instruction that follows shortly after that write does not read flash. It returns a configuration byte, chosen by the address in the 16-bit Z pointer.

A load that falls outside the window, or that comes after the flags have cleared, returns the addressed flash byte. Each flash word holds two bytes, and bit 0 of Z selects which byte comes back. A store instruction issued inside the window also clears the flags, and no flash write takes place. While an EEPROM write is in progress, register writes are refused and configuration reads are withheld. The flash array is a synchronous read-only stub whose contents follow a fixed formula.

Top module: `cfgrd_top`

## Requirements
- R1: After synchronous reset, `ctl_rdata` reads 0x00 and `ld_valid` is 0.
- R2: A load with no special read pending raises `ld_valid` for exactly the following cycle. In that cycle `ld_data` holds the byte at address Z. The flash word index is Z[6:1] and higher Z bits are ignored. Word i holds the low byte `i ^ 0xC3` and the high byte `i ^ 0x3C`, with `i` zero-extended to 8 bits. Z[0]=0 selects the low byte and Z[0]=1 selects the high byte.
- R3: In the control register, bit 0 is the enable flag and bit 3 is the read-configuration flag. All other bits read 0. A write with bit 0 clear leaves both flags at 0.
- R4: While both flags are set, a load with Z=0x0000 returns the `fuse_low` input and clears both flags.
- R5: While both flags are set, a load with Z=0x0001 returns the lock byte. Bit 1 of that byte carries `lock_bits[1]` and bit 0 carries `lock_bits[0]`. Bits 7..2 read 1.
- R6: While both flags are set, a load at any other Z returns 0xFF.
- R7: Once both flags are written, they stay set for exactly 3 cycles after the write edge and then clear. A load in a 4th or later cycle returns flash data.
- R8: A write that sets only the enable flag keeps it set for exactly 4 cycles after the write edge, then clears it. Loads return flash data throughout.
- R9: A store strobe while the enable flag is set clears both flags. Flash contents are not changed.
- R10: While `ee_busy` is high, control register writes have no effect.
- R11: While `ee_busy` is high, a load returns flash data even with both flags set, and it does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| z_ptr | input | 16 | Byte address pointer |
| lpm_stb | input | 1 | Program-memory load instruction strobe |
| spm_stb | input | 1 | Store-program-memory instruction strobe |
| ee_busy | input | 1 | EEPROM write in progress |
| fuse_low | input | 8 | Fuse low byte value |
| lock_bits | input | 2 | Lock bit values |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 8 | Load result byte |

## Verification
Every byte address of the flash stub is loaded with no special read pending. This separates word indexing from byte selection.

The special read is then armed, and a load follows at each delay from 0 to 3 cycles. Each delay is run with Z at 0, 1, 2, 0x80 and 0xFFFF, and with the lock and fuse values varied. These runs separate the three configuration answers from each other. They also separate the edge of the load window from the first cycle after it.

Per-cycle readback of the register after each write tells the 3-cycle load window from the 4-cycle store window. Runs with store strobes and with `ee_busy` held high, both while the flags are set, check the clearing and blocking rules.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

    localparam int CTL_EN_BIT = 0;
    localparam int CTL_RD_BIT = 3;
    localparam logic [15:0] Z_FUSE = 16'h0000;
    localparam logic [15:0] Z_LOCK = 16'h0001;

    typedef struct packed {
        logic rd;
        logic en;
    } ctl_flags_t;

    typedef enum logic {
        SRC_FLASH = 1'b0,
        SRC_CFG   = 1'b1
    } ld_src_e;

    typedef struct packed {
        logic       valid;
        ld_src_e    src;
        logic       hi;
        logic [7:0] cfg;
    } ld_tag_t;

    function automatic logic [15:0] flash_word(input logic [7:0] idx);
        return {idx ^ 8'h3C, idx ^ 8'hC3};
    endfunction

    function automatic logic [7:0] cfg_byte(input logic [15:0] z,
                                            input logic [7:0]  fuse,
                                            input logic [1:0]  lock);
        if (z == Z_FUSE)      return fuse;
        else if (z == Z_LOCK) return {6'h3F, lock};
        else                  return 8'hFF;
    endfunction

    function automatic logic [7:0] pack_ctl(input ctl_flags_t f);
        logic [7:0] r;
        r = 8'h00;
        r[CTL_EN_BIT] = f.en;
        r[CTL_RD_BIT] = f.rd;
        return r;
    endfunction

endpackage

// File: rtl/cfgrd_flash_stub.sv
module cfgrd_flash_stub
    import cfgrd_pkg::*;
#(
    parameter int WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [WORD_AW-1:0] rd_idx,
    output logic [15:0]        rd_word
);
    always_ff @(posedge clk) begin
        if (rst)        rd_word <= 16'h0000;
        else if (rd_en) rd_word <= flash_word(8'(rd_idx));
    end
endmodule

// File: rtl/cfgrd_ctrl.sv
module cfgrd_ctrl
    import cfgrd_pkg::*;
#(
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       ee_busy,
    input  logic       lpm_stb,
    input  logic       spm_stb,
    output ctl_flags_t flags,
    output logic       cfg_hit
);
    localparam int MAX_WIN = (LOAD_WIN > STORE_WIN) ? LOAD_WIN : STORE_WIN;
    localparam int AGE_W   = $clog2(MAX_WIN + 1);

    logic [AGE_W-1:0] age;
    logic wr_ok, armed, load_exp, store_exp, spm_clr, drop;

    always_comb begin
        wr_ok     = ctl_we && !ee_busy;
        armed     = flags.en && flags.rd;
        cfg_hit   = armed && lpm_stb && !ee_busy;
        load_exp  = armed && (age == AGE_W'(LOAD_WIN - 1));
        store_exp = flags.en && (age == AGE_W'(STORE_WIN - 1));
        spm_clr   = flags.en && spm_stb;
        drop      = cfg_hit || spm_clr || load_exp || store_exp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            age   <= '0;
        end else if (wr_ok) begin
            flags.en <= ctl_wdata[CTL_EN_BIT];
            flags.rd <= ctl_wdata[CTL_RD_BIT] && ctl_wdata[CTL_EN_BIT];
            age      <= '0;
        end else if (flags.en) begin
            if (drop) begin
                flags <= '0;
                age   <= '0;
            end else begin
                age <= age + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgrd_load_path.sv
module cfgrd_load_path
    import cfgrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lpm_stb,
    input  logic        cfg_hit,
    input  logic [15:0] z_ptr,
    input  logic [7:0]  fuse_low,
    input  logic [1:0]  lock_bits,
    input  logic [15:0] flash_word_q,
    output logic        ld_valid,
    output logic [7:0]  ld_data
);
    ld_tag_t tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag <= '0;
        end else begin
            tag.valid <= lpm_stb;
            if (lpm_stb) begin
                tag.src <= cfg_hit ? SRC_CFG : SRC_FLASH;
                tag.hi  <= z_ptr[0];
                tag.cfg <= cfg_byte(z_ptr, fuse_low, lock_bits);
            end
        end
    end

    always_comb begin
        ld_valid = tag.valid;
        if (!tag.valid)              ld_data = 8'h00;
        else if (tag.src == SRC_CFG) ld_data = tag.cfg;
        else if (tag.hi)             ld_data = flash_word_q[15:8];
        else                         ld_data = flash_word_q[7:0];
    end
endmodule

// File: rtl/cfgrd_top.sv
module cfgrd_top
    import cfgrd_pkg::*;
#(
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4,
    parameter int WORD_AW   = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic [15:0] z_ptr,
    input  logic        lpm_stb,
    input  logic        spm_stb,
    input  logic        ee_busy,
    input  logic [7:0]  fuse_low,
    input  logic [1:0]  lock_bits,
    output logic        ld_valid,
    output logic [7:0]  ld_data
);
    ctl_flags_t  flags;
    logic        cfg_hit;
    logic [15:0] word_q;

    cfgrd_ctrl #(.LOAD_WIN(LOAD_WIN), .STORE_WIN(STORE_WIN)) u_ctrl (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ee_busy(ee_busy), .lpm_stb(lpm_stb), .spm_stb(spm_stb),
        .flags(flags), .cfg_hit(cfg_hit)
    );

    cfgrd_flash_stub #(.WORD_AW(WORD_AW)) u_flash (
        .clk(clk), .rst(rst), .rd_en(lpm_stb),
        .rd_idx(z_ptr[WORD_AW:1]), .rd_word(word_q)
    );

    cfgrd_load_path u_path (
        .clk(clk), .rst(rst), .lpm_stb(lpm_stb), .cfg_hit(cfg_hit),
        .z_ptr(z_ptr), .fuse_low(fuse_low), .lock_bits(lock_bits),
        .flash_word_q(word_q), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    assign ctl_rdata = pack_ctl(flags);
endmodule

// File: rtl/cfgrd_checker.sv
module cfgrd_checker #(
    parameter int STORE_WIN = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        ctl_we,
    input logic [7:0]  ctl_rdata,
    input logic [15:0] z_ptr,
    input logic        lpm_stb,
    input logic        ee_busy,
    input logic [7:0]  fuse_low,
    input logic        ld_valid,
    input logic [7:0]  ld_data
);
    logic [31:0] en_run;
    logic        armed;

    assign armed = ctl_rdata[0] && ctl_rdata[3];

    always_ff @(posedge clk) begin
        if (rst)                     en_run <= 0;
        else if (ctl_we && !ee_busy) en_run <= 0;
        else if (ctl_rdata[0])       en_run <= en_run + 1;
        else                         en_run <= 0;
    end

    // R2: a result follows every load by one cycle
    assert_load_valid_R2: assert property (@(posedge clk) disable iff (rst)
        lpm_stb |=> ld_valid);

    // R3: read flag never stands without the enable flag
    assert_rd_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[3] |-> ctl_rdata[0]);

    // R3: unused register bits stay zero
    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata & 8'hF6) == 8'h00);

    // R4: armed fuse read returns fuse byte and clears flags
    assert_fuse_read_R4: assert property (@(posedge clk) disable iff (rst)
        armed && lpm_stb && !ee_busy && !ctl_we && z_ptr == 16'h0000
        |=> ld_data == $past(fuse_low) && ctl_rdata == 8'h00);

    // R8: enable flag never outlives the store window
    assert_window_bound_R8: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[0] |-> en_run < STORE_WIN);

    // R10: a blocked write does not set flags
    assert_busy_block_R10: assert property (@(posedge clk) disable iff (rst)
        ee_busy && ctl_we && ctl_rdata == 8'h00 |=> ctl_rdata == 8'h00);

    // R11: a load during EEPROM write leaves armed flags in place
    assert_busy_keep_R11: assert property (@(posedge clk) disable iff (rst)
        armed && lpm_stb && ee_busy && !ctl_we && $past(armed) && $past(ctl_we) && !$past(ee_busy)
        |=> armed);
endmodule

bind cfgrd_top cfgrd_checker #(.STORE_WIN(STORE_WIN)) u_chk (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
    .z_ptr(z_ptr), .lpm_stb(lpm_stb), .ee_busy(ee_busy),
    .fuse_low(fuse_low), .ld_valid(ld_valid), .ld_data(ld_data)
);

// File: tb/sim_cfgrd_top.sv
`timescale 1ns/1ps
module sim_cfgrd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_rdata;
    logic [15:0] z_ptr = 16'h0000;
    logic        lpm_stb = 1'b0;
    logic        spm_stb = 1'b0;
    logic        ee_busy = 1'b0;
    logic [7:0]  fuse_low = 8'h00;
    logic [1:0]  lock_bits = 2'b00;
    logic        ld_valid;
    logic [7:0]  ld_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    cfgrd_top u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .z_ptr(z_ptr), .lpm_stb(lpm_stb),
        .spm_stb(spm_stb), .ee_busy(ee_busy), .fuse_low(fuse_low),
        .lock_bits(lock_bits), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    function automatic logic [7:0] exp_flash(input logic [15:0] z);
        int idx;
        idx = (z >> 1) % 64;
        if (z[0]) return 8'((idx ^ 32'h3C) & 32'hFF);
        else      return 8'((idx ^ 32'hC3) & 32'hFF);
    endfunction

    function automatic logic [7:0] exp_cfg(input logic [15:0] z,
                                           input logic [7:0] f,
                                           input logic [1:0] l);
        if (z == 16'd0) return f;
        if (z == 16'd1) return 8'd252 + 8'(l);
        return 8'd255;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] z, output logic v, output logic [7:0] d);
        z_ptr = z; lpm_stb = 1'b1;
        step();
        lpm_stb = 1'b0;
        v = ld_valid; d = ld_data;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic v;
        logic [7:0] d;
        logic [15:0] zs [5];
        zs[0] = 16'h0000; zs[1] = 16'h0001; zs[2] = 16'h0002;
        zs[3] = 16'h0080; zs[4] = 16'hFFFF;

        repeat (3) step();
        rst = 1'b0;
        check("R1 ctl", 32'(ctl_rdata), 32'h00);
        check("R1 valid", 32'(ld_valid), 32'h0);

        // R2: full byte sweep with no special read pending
        for (int a = 0; a < 128; a++) begin
            do_load(16'(a), v, d);
            check("R2 valid", 32'(v), 32'h1);
            check("R2 data", 32'(d), 32'(exp_flash(16'(a))));
        end
        do_load(16'h8005, v, d);
        check("R2 upper Z bits ignored", 32'(d), 32'(exp_flash(16'h0005)));
        step();
        check("R2 valid one cycle", 32'(ld_valid), 32'h0);

        // R3: register encoding
        do_write(8'hFF);
        check("R3 both flags", 32'(ctl_rdata), 32'h09);
        repeat (4) step();
        do_write(8'h08);
        check("R3 read flag w/o enable", 32'(ctl_rdata), 32'h00);

        // R8: enable only, 4-cycle window, loads normal
        do_write(8'h01);
        for (int k = 1; k <= 5; k++) begin
            check("R8 window", 32'(ctl_rdata), (k <= 4) ? 32'h01 : 32'h00);
            step();
        end
        do_write(8'h01);
        do_load(16'h0000, v, d);
        check("R8 load normal", 32'(d), 32'(exp_flash(16'h0000)));
        repeat (4) step();

        // R7: both flags, 3-cycle window
        do_write(8'h09);
        for (int k = 1; k <= 4; k++) begin
            check("R7 window", 32'(ctl_rdata), (k <= 3) ? 32'h09 : 32'h00);
            step();
        end

        // R4 R5 R6 R7: armed loads at every delay and address class
        for (int zi = 0; zi < 5; zi++) begin
            for (int dl = 0; dl < 4; dl++) begin
                fuse_low  = 8'(8'h5A ^ (zi * 17 + dl * 3));
                lock_bits = 2'(dl + zi);
                do_write(8'h09);
                repeat (dl) step();
                do_load(zs[zi], v, d);
                if (dl < 3) begin
                    if (zi == 0)      check("R4 fuse", 32'(d), 32'(exp_cfg(zs[zi], fuse_low, lock_bits)));
                    else if (zi == 1) check("R5 lock", 32'(d), 32'(exp_cfg(zs[zi], fuse_low, lock_bits)));
                    else              check("R6 other", 32'(d), 32'(exp_cfg(zs[zi], fuse_low, lock_bits)));
                    check("R4 flags cleared", 32'(ctl_rdata), 32'h00);
                end else begin
                    check("R7 expired load", 32'(d), 32'(exp_flash(zs[zi])));
                end
                step();
            end
        end

        // R9: store clears, flash intact
        do_write(8'h09);
        step();
        spm_stb = 1'b1; step(); spm_stb = 1'b0;
        check("R9 cleared", 32'(ctl_rdata), 32'h00);
        do_load(16'h0000, v, d);
        check("R9 normal after store", 32'(d), 32'(exp_flash(16'h0000)));
        do_write(8'h01);
        spm_stb = 1'b1; step(); spm_stb = 1'b0;
        check("R9 enable only cleared", 32'(ctl_rdata), 32'h00);
        for (int a = 0; a < 8; a++) begin
            do_load(16'(a), v, d);
            check("R9 flash unchanged", 32'(d), 32'(exp_flash(16'(a))));
        end

        // R10: blocked writes
        ee_busy = 1'b1;
        do_write(8'h09);
        check("R10 set blocked", 32'(ctl_rdata), 32'h00);
        ee_busy = 1'b0;
        do_write(8'h09);
        ee_busy = 1'b1;
        do_write(8'h00);
        check("R10 clear blocked", 32'(ctl_rdata), 32'h09);
        ee_busy = 1'b0;
        repeat (4) step();

        // R11: load while busy
        fuse_low = 8'hA7; lock_bits = 2'b10;
        do_write(8'h09);
        ee_busy = 1'b1;
        do_load(16'h0000, v, d);
        check("R11 busy load flash", 32'(d), 32'(exp_flash(16'h0000)));
        check("R11 flags kept", 32'(ctl_rdata), 32'h09);
        ee_busy = 1'b0;
        do_load(16'h0001, v, d);
        check("R11 later lock read", 32'(d), 32'hFE);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule